// File: doc/BRIEF.md
# Bit-Slip Word Aligner with Boundary Report

This block sits behind a deserializer. It takes raw parallel words whose bit boundary is arbitrary and finds where the real symbol boundary lies. Words are 10 or 20 bits wide, chosen by a mode input. The block looks for a 7-bit comma pattern at every bit offset of a two-word window, which holds the previous word followed by the current one. When it finds one, it slips the word boundary so that the comma starts each aligned word and raises a sync flag.

The block also reports on a 5-bit port how far it slipped, so that logic downstream can correct the link latency to a fixed figure. The encoding of that report depends on the mode. Before lock, the port holds a fixed value for each mode. After lock, the slip stays frozen until repeated misplaced commas drop the sync flag and a new search starts. Code-group decoding, disparity checks and all clock logic live outside this block.

Top module: `bitSlipAligner`

## Requirements
- R1: While `rst` is high, the block latches `modeSel` (1 selects 20-bit words, 0 selects 10-bit words). One edge into reset, `syncFlag` is 0, `boundary` shows the unlocked value for the latched mode and `alignedData` is 0.
- R2: Words arrive with bit 0 first. The search window is the previous word followed by the current word. A comma is any 7 consecutive window bits whose value, with the earliest bit as bit 0, equals 7'b0011111 or 7'b1100000. A run of ones or zeros that is too short or too long does not match.
- R3: While unlocked, `syncFlag` rises at the edge that samples the first word whose window holds a comma. A slip s means the aligned word takes the last s bits of the previous word followed by the first word-width-minus-s bits of the current word.
- R4: In 10-bit mode, the locked `boundary` equals the slip s (0 to 9).
- R5: In 20-bit mode, the locked `boundary` equals 19 minus s, so zero slip reads 19.
- R6: While unlocked, `boundary` holds 5'b01111 in 10-bit mode and 5'b11111 in 20-bit mode.
- R7: `alignedData` is registered exactly one edge after the word it is taken from. Before lock it carries that word unslipped. In 10-bit mode, bits 19:10 of `alignedData` are 0 and bits 19:10 of `rawData` are ignored.
- R8: When several offsets in one window match, the smallest slip wins. At the lock edge `alignedData` already starts with the comma.
- R9: After lock, the slip and `boundary` stay frozen. A run of fewer than four words with a comma only at other offsets changes neither.
- R10: A word is bad when its window holds a comma but none at the locked slip. A word with a comma at the locked slip, or with no comma, clears the run. The fourth consecutive bad word drops `syncFlag` and restores the unlocked `boundary` value at that edge.
- R11: A change of `modeSel` outside reset has no effect on mode, slip selection or `boundary` encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset; mode is latched while high |
| modeSel | input | 1 | 1 = 20-bit words, 0 = 10-bit words |
| rawData | input | 20 | Unaligned received word, bit 0 first; only bits 9:0 used in 10-bit mode |
| alignedData | output | 20 | Word after slip, one edge later |
| syncFlag | output | 1 | High while aligned |
| boundary | output | 5 | Slip report, or the unlocked value |

## Verification
Every result of this block is due at the single clock edge that samples the input word. At that edge, `syncFlag`, `boundary` and `alignedData` all update together, and loss of sync shows on the edge of the fourth bad word. The bench therefore changes `rawData` 1 ns after an edge and reads all three outputs 1 ns after the next edge. It uses a word-by-word reference model that predicts the state for that one edge. Directed slips, double matches, near-miss patterns and a mode change outside reset are checked against values written out from the requirements. Random words cover the rest.

// File: rtl/bitSlipAlignPkg.sv
package bitSlipAlignPkg;
  localparam int COMMA_LEN = 7;
  localparam logic [COMMA_LEN-1:0] COMMA_PLUS  = 7'b0011111;
  localparam logic [COMMA_LEN-1:0] COMMA_MINUS = 7'b1100000;
  localparam logic [4:0] UNLOCK_SHORT = 5'b01111;
  localparam logic [4:0] UNLOCK_LONG  = 5'b11111;

  // strobes from control to datapath
  typedef struct packed {
    logic       locked;
    logic [4:0] slip;
  } alignStrobe_t;

  function automatic logic isComma(input logic [COMMA_LEN-1:0] seg);
    return (seg == COMMA_PLUS) || (seg == COMMA_MINUS);
  endfunction

  function automatic logic [4:0] unlockValue(input logic modeLong);
    return modeLong ? UNLOCK_LONG : UNLOCK_SHORT;
  endfunction
endpackage

// File: rtl/alignCommaScan.sv
module alignCommaScan
  import bitSlipAlignPkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic [2*WORD_W-1:0] window,
  output logic [WORD_W-1:0]   hits
);
  // hits[s]: comma starts s bits before bit 0 of the current word
  for (genvar s = 0; s < WORD_W; s++) begin : g_offset
    assign hits[s] = isComma(window[WORD_W - s +: COMMA_LEN]);
  end
endmodule

// File: rtl/alignDatapath.sv
module alignDatapath
  import bitSlipAlignPkg::*;
#(
  parameter int MAX_W   = 20,
  parameter int SHORT_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [MAX_W-1:0]   rawData,
  input  logic               modeLong,
  input  alignStrobe_t       strobe,
  output logic [MAX_W-1:0]   hits,
  output logic [MAX_W-1:0]   alignedData
);
  localparam int LONG_SEL_W  = $clog2(2*MAX_W);
  localparam int SHORT_SEL_W = $clog2(2*SHORT_W);
  localparam int PAD_W       = MAX_W - SHORT_W;

  logic [MAX_W-1:0]       prevWord;
  logic [2*MAX_W-1:0]     windowLong;
  logic [2*SHORT_W-1:0]   windowShort;
  logic [MAX_W-1:0]       hitsLong;
  logic [SHORT_W-1:0]     hitsShort;
  logic [LONG_SEL_W-1:0]  amtLong;
  logic [SHORT_SEL_W-1:0] amtShort;
  logic [MAX_W-1:0]       alignedLong;
  logic [SHORT_W-1:0]     alignedShort;
  logic [MAX_W-1:0]       alignedNext;

  assign windowLong  = {rawData, prevWord};
  assign windowShort = {rawData[SHORT_W-1:0], prevWord[SHORT_W-1:0]};

  alignCommaScan #(.WORD_W(MAX_W)) i_scanLong (
    .window(windowLong),
    .hits  (hitsLong)
  );

  alignCommaScan #(.WORD_W(SHORT_W)) i_scanShort (
    .window(windowShort),
    .hits  (hitsShort)
  );

  assign hits = modeLong ? hitsLong : {{PAD_W{1'b0}}, hitsShort};

  // slip s selects the word starting s bits before the current word
  assign amtLong      = LONG_SEL_W'(MAX_W) - LONG_SEL_W'(strobe.slip);
  assign amtShort     = SHORT_SEL_W'(SHORT_W) - SHORT_SEL_W'(strobe.slip);
  assign alignedLong  = windowLong[amtLong +: MAX_W];
  assign alignedShort = windowShort[amtShort +: SHORT_W];
  assign alignedNext  = modeLong ? alignedLong : {{PAD_W{1'b0}}, alignedShort};

  always_ff @(posedge clk) begin
    if (rst) begin
      prevWord    <= '0;
      alignedData <= '0;
    end else begin
      prevWord    <= rawData;
      alignedData <= alignedNext;
    end
  end

  // R7: short mode keeps the upper output bits clear
  a_r7_short_upper_zero: assert property (@(posedge clk) disable iff (rst)
    !modeLong |=> (alignedData[MAX_W-1:SHORT_W] == '0));

  // R7: before lock with no comma the word passes through unslipped, one edge late
  a_r7_prelock_passthru: assert property (@(posedge clk) disable iff (rst)
    (!strobe.locked && (hits == '0)) |=>
      (alignedData[SHORT_W-1:0] == $past(rawData[SHORT_W-1:0])));
endmodule

// File: rtl/alignControl.sv
module alignControl
  import bitSlipAlignPkg::*;
#(
  parameter int MAX_W      = 20,
  parameter int SHORT_W    = 10,
  parameter int LOSS_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             modeSel,
  input  logic [MAX_W-1:0] hits,
  output logic             modeLong,
  output alignStrobe_t     strobe,
  output logic             syncFlag,
  output logic [4:0]       boundary
);
  localparam int CNT_W = (LOSS_LIMIT > 2) ? $clog2(LOSS_LIMIT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOSS_LIMIT - 1);
  localparam logic [4:0] LONG_TOP = 5'(MAX_W - 1);

  logic [4:0]       slipReg;
  logic [4:0]       lowSlip;
  logic [CNT_W-1:0] badCnt;
  logic             found;
  logic             badWord;

  function automatic logic [4:0] encodeBoundary(input logic m, input logic [4:0] s);
    return m ? (LONG_TOP - s) : s;
  endfunction

  // smallest matching slip wins
  always_comb begin
    lowSlip = '0;
    for (int i = MAX_W - 1; i >= 0; i--) begin
      if (hits[i]) lowSlip = 5'(i);
    end
  end

  assign found   = |hits;
  assign badWord = found && !hits[slipReg];

  assign strobe.locked = syncFlag;
  assign strobe.slip   = syncFlag ? slipReg : (found ? lowSlip : 5'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      modeLong <= modeSel;
      syncFlag <= 1'b0;
      slipReg  <= '0;
      badCnt   <= '0;
      boundary <= unlockValue(modeSel);
    end else if (!syncFlag) begin
      if (found) begin
        syncFlag <= 1'b1;
        slipReg  <= lowSlip;
        badCnt   <= '0;
        boundary <= encodeBoundary(modeLong, lowSlip);
      end
    end else if (badWord) begin
      if (badCnt == CNT_LAST) begin
        syncFlag <= 1'b0;
        badCnt   <= '0;
        boundary <= unlockValue(modeLong);
      end else begin
        badCnt <= badCnt + 1'b1;
      end
    end else begin
      badCnt <= '0;
    end
  end

  a_r6_unlocked_value: assert property (@(posedge clk) disable iff (rst)
    !syncFlag |-> (boundary == unlockValue(modeLong)));

  a_r3_lock_on_hit: assert property (@(posedge clk) disable iff (rst)
    (!syncFlag && found) |=> syncFlag);

  a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
    (syncFlag && $past(syncFlag)) |-> $stable(boundary));

  a_r10_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    (syncFlag && !found) |=> syncFlag);

  a_r4_short_range: assert property (@(posedge clk) disable iff (rst)
    (syncFlag && !modeLong) |-> (boundary < 5'(SHORT_W)));

  a_r5_long_range: assert property (@(posedge clk) disable iff (rst)
    (syncFlag && modeLong) |-> (boundary <= LONG_TOP));

  a_r11_mode_held: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(modeLong));
endmodule

// File: rtl/bitSlipAligner.sv
module bitSlipAligner
  import bitSlipAlignPkg::*;
#(
  parameter int MAX_W      = 20,
  parameter int SHORT_W    = 10,
  parameter int LOSS_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             modeSel,
  input  logic [MAX_W-1:0] rawData,
  output logic [MAX_W-1:0] alignedData,
  output logic             syncFlag,
  output logic [4:0]       boundary
);
  alignStrobe_t     strobe;
  logic [MAX_W-1:0] hits;
  logic             modeLong;

  alignDatapath #(.MAX_W(MAX_W), .SHORT_W(SHORT_W)) i_datapath (
    .clk        (clk),
    .rst        (rst),
    .rawData    (rawData),
    .modeLong   (modeLong),
    .strobe     (strobe),
    .hits       (hits),
    .alignedData(alignedData)
  );

  alignControl #(.MAX_W(MAX_W), .SHORT_W(SHORT_W), .LOSS_LIMIT(LOSS_LIMIT)) i_control (
    .clk     (clk),
    .rst     (rst),
    .modeSel (modeSel),
    .hits    (hits),
    .modeLong(modeLong),
    .strobe  (strobe),
    .syncFlag(syncFlag),
    .boundary(boundary)
  );

  // R8: at the lock edge the aligned word already begins with a comma
  a_r8_comma_leads: assert property (@(posedge clk) disable iff (rst)
    $rose(syncFlag) |-> isComma(alignedData[COMMA_LEN-1:0]));
endmodule

// File: tb/test_bitSlipAligner.sv
`timescale 1ns/1ps
module test_bitSlipAligner;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        modeSel = 1'b0;
  logic [19:0] rawData = '0;
  logic [19:0] alignedData;
  logic        syncFlag;
  logic [4:0]  boundary;

  int nChecks = 0;
  int nFails  = 0;

  // reference model state
  bit          mMode;
  bit          mSync;
  int          mSlip;
  int          mBad;
  logic [19:0] prevW;
  logic [19:0] expOut;
  int          expBound;

  localparam logic [19:0] F10 = 20'h00155;
  localparam logic [19:0] A10 = 20'h0029F;
  localparam logic [19:0] F20 = 20'h55555;
  localparam logic [19:0] A20 = 20'h5569F;

  always #2 clk = ~clk;

  bitSlipAligner i_bitSlipAligner (
    .clk(clk), .rst(rst), .modeSel(modeSel), .rawData(rawData),
    .alignedData(alignedData), .syncFlag(syncFlag), .boundary(boundary)
  );

  task automatic checkEq(input string tag, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [19:0] hitVec(input logic [19:0] cur, input logic [19:0] prev, input bit m);
    logic [39:0] w;
    logic [6:0]  seg;
    logic [19:0] hv;
    int          n;
    n  = m ? 20 : 10;
    w  = m ? {cur, prev} : {20'd0, cur[9:0], prev[9:0]};
    hv = '0;
    for (int s = 0; s < n; s++) begin
      seg = w[(n - s) +: 7];
      hv[s] = (seg == 7'h1F) || (seg == 7'h60);
    end
    return hv;
  endfunction

  function automatic int unlockVal(input bit m);
    return m ? 31 : 15;
  endfunction

  // raw word for aligned words a, aNext under slip s
  function automatic logic [19:0] skew(input logic [19:0] a, input logic [19:0] aNext, input int s, input bit m);
    logic [19:0] mask;
    int n;
    n    = m ? 20 : 10;
    mask = m ? 20'hFFFFF : 20'h003FF;
    if (s == 0) return a & mask;
    return ((a >> s) | (aNext << (n - s))) & mask;
  endfunction

  task automatic modelAdvance(input logic [19:0] cur);
    logic [19:0] hv;
    logic [39:0] w;
    int n, sel;
    n  = mMode ? 20 : 10;
    w  = mMode ? {cur, prevW} : {20'd0, cur[9:0], prevW[9:0]};
    hv = hitVec(cur, prevW, mMode);
    sel = 0;
    if (!mSync) begin
      if (hv != '0) begin
        for (int s = n - 1; s >= 0; s--) if (hv[s]) sel = s;
        mSync = 1; mSlip = sel; mBad = 0;
      end
    end else begin
      sel = mSlip;
      if (hv != '0 && !hv[mSlip]) begin
        if (mBad == 3) begin mSync = 0; mBad = 0; end
        else mBad++;
      end else mBad = 0;
    end
    expOut   = 20'(w >> (n - sel)) & (mMode ? 20'hFFFFF : 20'h003FF);
    expBound = mSync ? (mMode ? 19 - mSlip : mSlip) : unlockVal(mMode);
    prevW    = cur;
  endtask

  task automatic step(input logic [19:0] cur);
    rawData = cur;
    modelAdvance(cur);
    @(posedge clk);
    #1;
    checkEq("R3", "syncFlag", syncFlag, mSync);
    checkEq(!mSync ? "R6" : (mMode ? "R5" : "R4"), "boundary", boundary, expBound);
    checkEq("R7", "alignedData", alignedData, expOut);
  endtask

  task automatic applyReset(input bit m);
    rst = 1'b1; modeSel = m; rawData = '0;
    repeat (3) @(posedge clk);
    #1;
    mMode = m; mSync = 0; mSlip = 0; mBad = 0; prevW = '0;
    checkEq("R1", "syncFlag in reset", syncFlag, 0);
    checkEq("R1", "boundary in reset", boundary, unlockVal(m));
    checkEq("R1", "alignedData in reset", alignedData, 0);
    rst = 1'b0;
  endtask

  task automatic runSlip(input int s, input bit m, input bit doReset, input string tag);
    logic [19:0] fw, aw;
    fw = m ? F20 : F10;
    aw = m ? A20 : A10;
    if (doReset) applyReset(m);
    for (int k = 0; k < 8; k++) begin
      step(skew(k == 3 ? aw : fw, k == 2 ? aw : fw, s, m));
    end
    checkEq(tag, "sync after slipped comma", syncFlag, 1);
    checkEq(tag, "boundary after slipped comma", boundary, m ? 19 - s : s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [19:0] pick;
    void'($urandom(32'h5EED1234));

    // R1 / R7: reset state and unslipped pass-through, upper input bits ignored
    applyReset(1'b0);
    step(20'hABC00 | 20'h0AA);
    checkEq("R7", "passthru low bits", alignedData, 20'h000AA);

    // R2: near misses do not lock, complement comma does
    applyReset(1'b0);
    step(F10); step(20'h0030F); step(F10);
    checkEq("R2", "near miss keeps unlocked", syncFlag, 0);
    step(20'h00060);
    checkEq("R2", "complement comma locks", syncFlag, 1);
    checkEq("R2", "complement comma slip", boundary, 0);

    // R4 / R5: directed slips
    runSlip(0, 1'b0, 1'b1, "R4");
    runSlip(3, 1'b0, 1'b1, "R4");
    runSlip(9, 1'b0, 1'b1, "R4");
    runSlip(0, 1'b1, 1'b1, "R5");
    runSlip(7, 1'b1, 1'b1, "R5");
    runSlip(19, 1'b1, 1'b1, "R5");

    // R8: two offsets match, smallest slip wins
    applyReset(1'b0);
    step(F10); step(20'h0007C);
    checkEq("R8", "no lock before double match", syncFlag, 0);
    step(20'h0001F);
    checkEq("R8", "lock on double match", syncFlag, 1);
    checkEq("R8", "smallest slip chosen", boundary, 0);
    checkEq("R8", "aligned starts with comma", alignedData[6:0], 7'h1F);

    // R9: three bad words then a good one keep lock
    for (int i = 0; i < 3; i++) step(20'h0007C);
    step(20'h0001F);
    checkEq("R9", "sync kept after three bad", syncFlag, 1);
    checkEq("R9", "boundary frozen", boundary, 0);

    // R10: four bad words drop lock
    for (int i = 0; i < 3; i++) step(20'h0007C);
    checkEq("R10", "sync kept after three bad", syncFlag, 1);
    step(20'h0007C);
    checkEq("R10", "sync lost on fourth bad", syncFlag, 0);
    checkEq("R10", "unlock value restored", boundary, 15);

    // R11: mode change outside reset is ignored
    applyReset(1'b0);
    modeSel = 1'b1;
    step(20'h00000); step(20'h00000);
    checkEq("R11", "boundary keeps short unlock value", boundary, 15);
    runSlip(4, 1'b0, 1'b0, "R11");

    // random phases
    applyReset(1'b0);
    for (int i = 0; i < 1500; i++) begin
      case ($urandom % 6)
        0: pick = F10;
        1: pick = A10;
        2: pick = 20'h0007C;
        3: pick = 20'h0001F;
        default: pick = 20'($urandom);
      endcase
      step(pick);
    end
    applyReset(1'b1);
    for (int i = 0; i < 1500; i++) begin
      case ($urandom % 4)
        0: pick = F20;
        1: pick = A20;
        default: pick = 20'($urandom);
      endcase
      step(pick);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule